// File: doc/BRIEF.md
# Context-Switch Microcode Sequencer

This block steps through a small stored microprogram that moves a graphics engine's register state between the engine's register file and a context memory. The program store is filled before use. A write to an index port sets the fill position, and each word written to the data port is stored at that position, which then steps by one. A start pulse runs the program from address 0. Each instruction either copies a run of registers, loads an immediate into a length register, branches on a flag, stalls on a flag, writes a flag, or issues a command. The end command stops the sequencer and raises done.

A 128-entry flag file steers the program. The flag index is formed as bank times 32 plus bit. Banks 0 to 2 are held inside the block and can be written by set instructions. Bank 3 mirrors external engine status inputs and cannot be written by the program. Flag 0 chooses the direction of every copy. Commands whose meaning the block does not implement, and words with undefined opcodes, are reported on a one-cycle pulse that carries the instruction word. Execution then continues.

Top module: `ctx_sequencer`

## Requirements
- R1: Writing `prog_idx` with `prog_idx_we` sets the fill index. Each `prog_data_we` stores `prog_wdata` at that index and then increments the index, so consecutive words occupy consecutive addresses.
- R2: On `start`, the next cycle shows `running`=1 and `done`=0, the program counter is 0, and the context position is 0.
- R3: A copy word has bits 23:20 = 0x1, a count in bits 19:14 and a first register index in bits 13:0. With flag 0 = 1 (save), it writes `count` context words. Register index+k goes to position+k, one word per cycle, and the position advances by `count`.
- R4: With flag 0 = 0 (load), the same copy word writes context word position+k into register index+k, one word per cycle. A save followed by a load over the same ranges restores the original register values.
- R5: A word with bits 23:20 = 0x2 loads bits 19:0 into the length register, which is visible on `seq_len`.
- R6: A word with bits 23:20 = 0x4 jumps to the address in bits 15:8 when the flag selected by bits 6:0 is 1 and bit 7 is 0, or when that flag is 0 and bit 7 is 1. Otherwise execution falls through to the next word.
- R7: A word with bits 23:20 = 0x5 holds the program counter until the flag selected by bits 6:0 equals bit 7.
- R8: A word with bits 23:20 = 0x7 writes bit 7 into the flag selected by bits 6:0 when that index is below 96. Writes to indices 96 to 127 have no effect.
- R9: Flag 96+b reads `eng_flags[b]`, except flag 104, which always reads 1.
- R10: Word 0x60000E clears `running` and sets `done`. `done` stays high until the next `start`.
- R11: Any other word with bits 23:20 = 0x6, and any word with an undefined opcode (0x0, 0x3 or 0x8 to 0xF), drives `cmd_valid` for one cycle, starting the cycle after the word executes, with `cmd_word` equal to the word. Execution continues with the next word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| prog_idx_we | input | 1 | Load the program fill index |
| prog_idx | input | AW | Fill index value |
| prog_data_we | input | 1 | Store a program word and step the index |
| prog_wdata | input | 24 | Program word |
| start | input | 1 | Run the program from address 0 |
| eng_flags | input | 32 | Engine status inputs, read as flag bank 3 |
| rf_addr | output | 14 | Register-file index |
| rf_we | output | 1 | Register-file write strobe (load copy) |
| rf_wdata | output | DW | Register-file write data |
| rf_rdata | input | DW | Register-file read data, combinational |
| cm_addr | output | CW | Context-memory word position |
| cm_we | output | 1 | Context-memory write strobe (save copy) |
| cm_wdata | output | DW | Context-memory write data |
| cm_rdata | input | DW | Context-memory read data, combinational |
| running | output | 1 | Program executing |
| done | output | 1 | End command reached |
| pc_o | output | AW | Program counter |
| seq_len | output | 20 | Length register |
| cmd_valid | output | 1 | Command or unknown-word pulse |
| cmd_word | output | 24 | Word that caused the pulse |

## Verification
The copy engine is exercised in both directions over two separate register runs with a command word between them. A save followed by a load over the same ranges, after the register file has been cleared, distinguishes a correct round trip from errors in the address stride, the position carry-over or the direction. Branches are tested on internal flags and on bank-3 inputs, in both polarities, with marker words placed on both paths. The resulting pulse sequence shows whether each jump was taken, and whether the forced-one flag and the write-protection of bank 3 behave as required. A wait on the busy input checks that the program counter holds while busy is high and that execution resumes once busy falls.

// File: rtl/ctx_sequencer.sv
module ctx_sequencer #(
  parameter int AW = 8,
  parameter int DW = 32,
  parameter int CW = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          prog_idx_we,
  input  logic [AW-1:0] prog_idx,
  input  logic          prog_data_we,
  input  logic [23:0]   prog_wdata,
  input  logic          start,
  input  logic [31:0]   eng_flags,
  output logic [13:0]   rf_addr,
  output logic          rf_we,
  output logic [DW-1:0] rf_wdata,
  input  logic [DW-1:0] rf_rdata,
  output logic [CW-1:0] cm_addr,
  output logic          cm_we,
  output logic [DW-1:0] cm_wdata,
  input  logic [DW-1:0] cm_rdata,
  output logic          running,
  output logic          done,
  output logic [AW-1:0] pc_o,
  output logic [19:0]   seq_len,
  output logic          cmd_valid,
  output logic [23:0]   cmd_word
);
  localparam int DEPTH = 1 << AW;
  localparam logic [23:0] W_END = 24'h60000E;

  logic [23:0]   store [DEPTH];
  logic [AW-1:0] fill_idx, pc;
  logic [95:0]   flags;
  logic          xfer;
  logic [5:0]    xcnt;
  logic [13:0]   xreg;
  logic [CW-1:0] pos;

  logic [23:0]   ins;
  logic [3:0]    op;
  logic [127:0]  fview;
  logic          fbit, fval;
  logic [6:0]    fidx;
  logic [AW-1:0] pc_nx;

  assign ins   = store[pc];
  assign op    = ins[23:20];
  assign fidx  = ins[6:0];
  assign fval  = ins[7];
  assign fview = {eng_flags | 32'h0000_0100, flags};
  assign fbit  = fview[fidx];
  assign pc_nx = pc + AW'(1);

  assign rf_addr  = xreg;
  assign cm_addr  = pos;
  assign cm_we    = xfer & flags[0];
  assign rf_we    = xfer & ~flags[0];
  assign cm_wdata = rf_rdata;
  assign rf_wdata = cm_rdata;
  assign pc_o     = pc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fill_idx <= '0;
    else if (prog_idx_we) fill_idx <= prog_idx;
    else if (prog_data_we) fill_idx <= fill_idx + AW'(1);
  end

  always_ff @(posedge clk) begin
    if (prog_data_we && !prog_idx_we) store[fill_idx] <= prog_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc <= '0; running <= 1'b0; done <= 1'b0; flags <= '0;
      xfer <= 1'b0; xcnt <= '0; xreg <= '0; pos <= '0;
      seq_len <= '0; cmd_valid <= 1'b0; cmd_word <= '0;
    end else begin
      cmd_valid <= 1'b0;
      if (start) begin
        pc <= '0; running <= 1'b1; done <= 1'b0; xfer <= 1'b0; pos <= '0;
      end else if (xfer) begin
        xreg <= xreg + 14'd1;
        pos  <= pos + CW'(1);
        xcnt <= xcnt - 6'd1;
        if (xcnt == 6'd1) begin
          xfer <= 1'b0;
          pc   <= pc_nx;
        end
      end else if (running) begin
        case (op)
          4'h1: begin
            if (ins[19:14] == 6'd0) pc <= pc_nx;
            else begin
              xfer <= 1'b1;
              xcnt <= ins[19:14];
              xreg <= ins[13:0];
            end
          end
          4'h2: begin
            seq_len <= ins[19:0];
            pc <= pc_nx;
          end
          4'h4: pc <= (fbit ^ fval) ? ins[8+AW-1:8] : pc_nx;
          4'h5: if (fbit == fval) pc <= pc_nx;
          4'h7: begin
            if (fidx < 7'd96) flags[fidx] <= fval;
            pc <= pc_nx;
          end
          4'h6: begin
            if (ins == W_END) begin
              running <= 1'b0;
              done    <= 1'b1;
            end else begin
              cmd_valid <= 1'b1;
              cmd_word  <= ins;
              pc <= pc_nx;
            end
          end
          default: begin
            cmd_valid <= 1'b1;
            cmd_word  <= ins;
            pc <= pc_nx;
          end
        endcase
      end
    end
  end

  p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (running && !done && pc == '0 && pos == '0));

  p_one_dir_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(cm_we && rf_we));

  p_pos_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((cm_we || rf_we) && !start) |=> pos == $past(pos) + CW'(1));

  p_wait_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !xfer && !start && op == 4'h5 && fbit != fval) |=> pc == $past(pc));

  p_done_stop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !running);

  p_cmd_src_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !$past(start)) |-> $past(running));
endmodule

// File: tb/test_ctx_sequencer.sv
`timescale 1ns/1ps
module test_ctx_sequencer;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n, prog_idx_we, prog_data_we, start;
  logic [7:0]  prog_idx;
  logic [23:0] prog_wdata;
  logic [31:0] eng_flags;
  logic [13:0] rf_addr;
  logic        rf_we, cm_we, running, done, cmd_valid;
  logic [31:0] rf_wdata, rf_rdata, cm_wdata, cm_rdata;
  logic [19:0] cm_addr, seq_len;
  logic [7:0]  pc_o;
  logic [23:0] cmd_word;

  logic [31:0] rf [16];
  logic [31:0] cm [64];
  assign rf_rdata = rf[rf_addr[3:0]];
  assign cm_rdata = cm[cm_addr[5:0]];

  ctx_sequencer i_ctx_sequencer (
    .clk(clk), .rst_n(rst_n), .prog_idx_we(prog_idx_we), .prog_idx(prog_idx),
    .prog_data_we(prog_data_we), .prog_wdata(prog_wdata), .start(start),
    .eng_flags(eng_flags), .rf_addr(rf_addr), .rf_we(rf_we), .rf_wdata(rf_wdata),
    .rf_rdata(rf_rdata), .cm_addr(cm_addr), .cm_we(cm_we), .cm_wdata(cm_wdata),
    .cm_rdata(cm_rdata), .running(running), .done(done), .pc_o(pc_o),
    .seq_len(seq_len), .cmd_valid(cmd_valid), .cmd_word(cmd_word));

  int tests = 0, fails = 0;
  logic [55:0] expq [$];
  logic [23:0] prog_q [$];

  function automatic logic [31:0] orig(int i);
    return 32'hA000_0000 + 32'(i) * 32'h111;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic push_exp(input logic [1:0] kind, input logic [21:0] addr, input logic [31:0] data);
    expq.push_back({kind, addr, data});
  endtask

  task automatic pop_cmp(input logic [55:0] got, input string req);
    if (expq.size() == 0) chk(1'b0, req, 64'(got), 64'hDEAD);
    else begin
      logic [55:0] e;
      e = expq.pop_front();
      chk(got == e, req, 64'(got), 64'(e));
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    if (cmd_valid) pop_cmp({2'd2, 22'd0, 8'd0, cmd_word}, "R11");
    if (cm_we)     pop_cmp({2'd0, 2'd0, cm_addr, cm_wdata}, "R3");
    if (rf_we)     pop_cmp({2'd1, 8'd0, rf_addr, rf_wdata}, "R4");
  end

  always @(posedge clk) begin
    if (cm_we) cm[cm_addr[5:0]] <= cm_wdata;
    if (rf_we) rf[rf_addr[3:0]] <= rf_wdata;
  end

  task automatic load_prog();
    @(negedge clk);
    prog_idx_we = 1'b1; prog_idx = 8'd0;
    @(negedge clk);
    prog_idx_we = 1'b0;
    foreach (prog_q[i]) begin
      prog_data_we = 1'b1; prog_wdata = prog_q[i];
      @(negedge clk);
    end
    prog_data_we = 1'b0;
  endtask

  task automatic run_prog(input string tag);
    int n = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(running && !done, "R2", {62'd0, running, done}, 64'h2);
    while (!done && n < 2000) begin
      @(negedge clk);
      n++;
    end
    chk(done && !running, "R10", {62'd0, running, done}, 64'h1);
    chk(expq.size() == 0, tag, 64'(expq.size()), 64'd0);
  endtask

  initial begin
    #500000;
    tests++; fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; prog_idx_we = 1'b0; prog_data_we = 1'b0; start = 1'b0;
    prog_idx = '0; prog_wdata = '0; eng_flags = '0;
    for (int i = 0; i < 16; i++) rf[i] <= orig(i);
    for (int i = 0; i < 64; i++) cm[i] <= 32'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!done && !running && !cmd_valid && !cm_we && !rf_we, "R2 reset",
        {59'd0, done, running, cmd_valid, cm_we, rf_we}, 64'd0);

    // R1 R3 R5 R11: save two ranges with a command between them
    prog_q = '{24'h700080, 24'h212345, 24'h110002, 24'h600007, 24'h108008, 24'h60000E};
    load_prog();
    for (int i = 0; i < 4; i++) push_exp(2'd0, 22'(i), orig(2 + i));
    push_exp(2'd2, 22'd0, 32'h00600007);
    push_exp(2'd0, 22'd4, orig(8));
    push_exp(2'd0, 22'd5, orig(9));
    run_prog("R1 save program order");
    chk(seq_len == 20'h12345, "R5", 64'(seq_len), 64'h12345);

    // R4: clear registers, load back
    @(negedge clk);
    for (int i = 0; i < 16; i++) rf[i] <= 32'h0;
    prog_q = '{24'h700000, 24'h110002, 24'h108008, 24'h60000E};
    load_prog();
    for (int i = 0; i < 4; i++) push_exp(2'd1, 22'(2 + i), orig(2 + i));
    push_exp(2'd1, 22'd8, orig(8));
    push_exp(2'd1, 22'd9, orig(9));
    run_prog("R4 load sequence");
    @(negedge clk);
    chk(rf[2] == orig(2), "R4 round trip", 64'(rf[2]), 64'(orig(2)));
    chk(rf[5] == orig(5), "R4 round trip", 64'(rf[5]), 64'(orig(5)));
    chk(rf[9] == orig(9), "R4 round trip", 64'(rf[9]), 64'(orig(9)));
    chk(rf[6] == 32'h0, "R4 untouched", 64'(rf[6]), 64'd0);

    // R6 R8 R9: branch polarities, read-only bank 3, forced-one flag
    prog_q = '{24'h700085, 24'h400405, 24'h900002, 24'h60000E,
               24'h400785, 24'h900005, 24'h7000E4, 24'h400A64,
               24'h900008, 24'h400B68, 24'h90000A, 24'h400D86,
               24'h90000C, 24'h60000E};
    load_prog();
    push_exp(2'd2, 22'd0, 32'h00900005);
    push_exp(2'd2, 22'd0, 32'h00900008);
    run_prog("R6 R8 R9 branch path");
    chk(pc_o == 8'd13, "R6 final pc", 64'(pc_o), 64'd13);

    // R7: wait on busy input
    prog_q = '{24'h500060, 24'h900011, 24'h60000E};
    load_prog();
    eng_flags = 32'h1;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int k = 0; k < 5; k++) begin
      chk(pc_o == 8'd0 && running, "R7 hold", 64'(pc_o), 64'd0);
      @(negedge clk);
    end
    push_exp(2'd2, 22'd0, 32'h00900011);
    eng_flags = 32'h0;
    begin
      int n = 0;
      while (!done && n < 100) begin
        @(negedge clk);
        n++;
      end
    end
    chk(done, "R7 resume", {63'd0, done}, 64'd1);
    chk(expq.size() == 0, "R7 R11 pulse", 64'(expq.size()), 64'd0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule